// File: doc/BRIEF.md
# Multithreaded Operation Issue Selector

This block is the dependency-check stage of one function unit in a machine that interleaves several hardware threads. It holds at most one buffered operation for each thread. Every cycle it decides which of those operations, if any, goes on to the register-read stage. The operand-availability test does not use register read ports. When one thread's operation is still waiting on a source, another thread's operation can go ahead in the same cycle, so the pipeline does not take a bubble.

Units that execute the same wide instruction of a thread stay in step through one "instruction not finished" line per thread. The line is the OR of every unit's contribution. A unit raises its contribution while it still holds an operation of that thread's current instruction that has not issued. Once a unit has issued its part of an instruction, it holds back that thread's next operation until the shared line is low.

Fetch keeps filling the buffer whatever the line state. An empty (null) slot in the instruction stream is accepted into the buffer like any other operation. It is retired without using the issue port, and it never raises the line.

Top module: `mt_issue_sel`

## Requirements
- R1: After reset, every buffer slot is empty, `slot_full`, `nd_out` and `iss_valid` are all zero.
- R2: A fill into thread t's slot is stored when the slot is empty or is leaving in that cycle, and `slot_full[t]` is high from the next cycle. A fill into a full slot that is not leaving is ignored: the held operation is unchanged.
- R3: A real operation is eligible only when each source marked used has its ready bit high. Bit `t*NUM_SRC+s` of `src_rdy` is source s of thread t's buffered operation. The ready bits of unused sources are ignored.
- R4: At most one operation issues per cycle. Among the eligible threads, the lowest thread index wins.
- R5: The issue outputs are combinational in the cycle of issue: `iss_tid`, opcode, destination and sources of the winning slot. That slot is empty from the next cycle unless it is refilled in the issue cycle.
- R6: `nd_out[t]` is high exactly when slot t holds a non-null operation and the unit has not yet issued its part of thread t's current instruction.
- R7: After the unit issues (or retires a null) for thread t, no further operation of t issues in any cycle where `nd_line[t]` is high. Once the line is seen low, operations of t may issue back to back, one per cycle.
- R8: A null operation (`fill_nop`=1) never drives `iss_valid` and never raises `nd_out`. It is retired as soon as thread t's ordering allows, and it counts as the unit's part of that instruction for R7.
- R9: Fills are accepted for a thread even while its line is high or the unit is holding that thread back.
- R10: A thread that is not eligible never stops a lower-priority eligible thread from issuing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A fetched operation is offered |
| fill_tid | input | TID_W | Thread of the offered operation |
| fill_nop | input | 1 | Offered slot is a null operation |
| fill_opc | input | OPC_W | Opcode |
| fill_dst | input | REG_W | Destination register |
| fill_used | input | NUM_SRC | Per-source used flags |
| fill_src | input | NUM_SRC*REG_W | Source registers, source s at bits s*REG_W |
| src_rdy | input | NUM_THREADS*NUM_SRC | Scoreboard ready bits of the buffered operations' sources |
| nd_line | input | NUM_THREADS | Per-thread OR of all units' not-done outputs |
| slot_full | output | NUM_THREADS | Slot occupancy per thread |
| nd_out | output | NUM_THREADS | This unit's not-done contribution per thread |
| iss_valid | output | 1 | An operation issues this cycle |
| iss_tid | output | TID_W | Thread of the issued operation |
| iss_opc | output | OPC_W | Opcode of the issued operation |
| iss_dst | output | REG_W | Destination of the issued operation |
| iss_src | output | NUM_SRC*REG_W | Sources of the issued operation |

## Verification
A wrong hold-back flag shows up quickly at the ports. An operation that issues while `nd_line` is high shows on `iss_valid` in that cycle. A held operation that never resumes shows after the line falls, as a missing issue. A corrupted slot shows when it issues, as a wrong opcode or source on the issue bus. A bad occupancy bit shows one cycle after the fill or issue on `slot_full` and `nd_out`. A priority fault shows as a wrong `iss_tid` in the first cycle where two threads are eligible together. The reference model runs beside the design and compares every output in every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/mtis_pkg.sv
package mtis_pkg;

    parameter int NUM_THREADS = 4;
    parameter int NUM_SRC     = 2;
    parameter int REG_W       = 6;
    parameter int OPC_W       = 8;
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
    localparam int SRCV_W     = NUM_SRC * REG_W;

    typedef struct packed {
        logic                             nop;
        logic [OPC_W-1:0]                 opc;
        logic [REG_W-1:0]                 dst;
        logic [NUM_SRC-1:0]               used;
        logic [NUM_SRC-1:0][REG_W-1:0]    src;
    } op_t;

    // every used source must be ready; unused ones do not matter
    function automatic logic srcs_ready(input logic [NUM_SRC-1:0] used,
                                        input logic [NUM_SRC-1:0] rdy);
        return &(rdy | ~used);
    endfunction

endpackage

// File: rtl/mtis_slot.sv
module mtis_slot
    import mtis_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  op_t                wr_op,
    input  logic [NUM_SRC-1:0] rdy,
    input  logic               line,
    input  logic               grant,
    output op_t                op,
    output logic               valid,
    output logic               want,
    output logic               nd
);

    logic held;      // own part of the current instruction already issued
    logic order_ok;
    logic nop_go;
    logic leave;
    logic accept;

    assign order_ok = !held || !line;
    assign want     = valid && !op.nop && srcs_ready(op.used, rdy) && order_ok;
    assign nop_go   = valid && op.nop && order_ok;
    assign leave    = grant || nop_go;
    assign accept   = wr_en && (!valid || leave);
    assign nd       = valid && !op.nop && !held;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= 1'b0;
            op    <= '0;
        end else begin
            if (accept) begin
                valid <= 1'b1;
                op    <= wr_op;
            end else if (leave) begin
                valid <= 1'b0;
            end
            if (leave)
                held <= 1'b1;
            else if (!line)
                held <= 1'b0;
        end
    end

    p_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (valid && !leave) |=> (valid && $stable(op)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (grant && !wr_en) |=> !valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        grant |=> (line |-> !grant));

    p_null_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && op.nop) |-> (!grant && !nd));

endmodule

// File: rtl/mtis_pick.sv
module mtis_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // fixed priority: lowest index wins
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
    import mtis_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           fill_valid,
    input  logic [TID_W-1:0]               fill_tid,
    input  logic                           fill_nop,
    input  logic [OPC_W-1:0]               fill_opc,
    input  logic [REG_W-1:0]               fill_dst,
    input  logic [NUM_SRC-1:0]             fill_used,
    input  logic [SRCV_W-1:0]              fill_src,
    input  logic [NUM_THREADS*NUM_SRC-1:0] src_rdy,
    input  logic [NUM_THREADS-1:0]         nd_line,
    output logic [NUM_THREADS-1:0]         slot_full,
    output logic [NUM_THREADS-1:0]         nd_out,
    output logic                           iss_valid,
    output logic [TID_W-1:0]               iss_tid,
    output logic [OPC_W-1:0]               iss_opc,
    output logic [REG_W-1:0]               iss_dst,
    output logic [SRCV_W-1:0]              iss_src
);

    op_t                    fill_op;
    op_t                    slot_op [NUM_THREADS];
    logic [NUM_THREADS-1:0] want;
    logic [NUM_THREADS-1:0] grant;
    logic [TID_W-1:0]       pick_idx;
    logic                   pick_any;
    op_t                    iss_op;

    always_comb begin
        fill_op.nop  = fill_nop;
        fill_op.opc  = fill_opc;
        fill_op.dst  = fill_dst;
        fill_op.used = fill_used;
        fill_op.src  = fill_src;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        mtis_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (fill_valid && (fill_tid == TID_W'(t))),
            .wr_op (fill_op),
            .rdy   (src_rdy[t*NUM_SRC +: NUM_SRC]),
            .line  (nd_line[t]),
            .grant (grant[t]),
            .op    (slot_op[t]),
            .valid (slot_full[t]),
            .want  (want[t]),
            .nd    (nd_out[t])
        );
    end

    mtis_pick #(.N(NUM_THREADS), .IDX_W(TID_W)) u_pick (
        .req   (want),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign iss_op    = pick_any ? slot_op[pick_idx] : '0;
    assign iss_valid = pick_any;
    assign iss_tid   = pick_idx;
    assign iss_opc   = iss_op.opc;
    assign iss_dst   = iss_op.dst;
    assign iss_src   = iss_op.src;

    p_one_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_prio_r4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> ((want & (grant - 1'b1)) == '0));

    p_iss_ready_r3: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> srcs_ready(iss_op.used, src_rdy[iss_tid*NUM_SRC +: NUM_SRC]));

endmodule

// File: tb/mt_issue_sel_bench.sv
`timescale 1ns/1ps
module mt_issue_sel_bench;
    import mtis_pkg::*;

    localparam int T = NUM_THREADS;
    localparam int S = NUM_SRC;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst;
    logic                 fill_valid, fill_nop;
    logic [TID_W-1:0]     fill_tid;
    logic [OPC_W-1:0]     fill_opc;
    logic [REG_W-1:0]     fill_dst;
    logic [S-1:0]         fill_used;
    logic [SRCV_W-1:0]    fill_src;
    logic [T*S-1:0]       src_rdy;
    logic [T-1:0]         other_nd, nd_line, slot_full, nd_out;
    logic                 iss_valid;
    logic [TID_W-1:0]     iss_tid;
    logic [OPC_W-1:0]     iss_opc;
    logic [REG_W-1:0]     iss_dst;
    logic [SRCV_W-1:0]    iss_src;

    assign nd_line = nd_out | other_nd;

    mt_issue_sel u_mt_issue_sel (
        .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_tid(fill_tid),
        .fill_nop(fill_nop), .fill_opc(fill_opc), .fill_dst(fill_dst),
        .fill_used(fill_used), .fill_src(fill_src), .src_rdy(src_rdy),
        .nd_line(nd_line), .slot_full(slot_full), .nd_out(nd_out),
        .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_opc(iss_opc),
        .iss_dst(iss_dst), .iss_src(iss_src)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit pending = 0;

    // behavioural reference: per-thread slot contents and hold-back flag
    bit                m_v [T], m_nop [T], m_hold [T];
    logic [OPC_W-1:0]  m_opc [T];
    logic [REG_W-1:0]  m_dst [T];
    logic [S-1:0]      m_used [T];
    logic [SRCV_W-1:0] m_src [T];
    bit                n_v [T], n_hold [T], n_take [T];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_compare();
        bit line [T];
        bit want [T];
        bit leave [T];
        int win;
        logic [T-1:0] exp_full, exp_nd;
        win = -1;
        for (int t = 0; t < T; t++) begin
            bit ok_src, order_ok;
            line[t] = (m_v[t] && !m_nop[t] && !m_hold[t]) || other_nd[t];
            order_ok = !m_hold[t] || !line[t];
            ok_src = 1;
            for (int s = 0; s < S; s++)
                if (m_used[t][s] && !src_rdy[t*S+s]) ok_src = 0;
            want[t] = m_v[t] && !m_nop[t] && ok_src && order_ok;
            if (want[t] && win < 0) win = t;
            leave[t] = (m_v[t] && m_nop[t] && order_ok);
            exp_full[t] = m_v[t];
            exp_nd[t] = m_v[t] && !m_nop[t] && !m_hold[t];
        end
        if (win >= 0) leave[win] = 1;
        chk(slot_full == exp_full, "R2 slot_full", slot_full, exp_full);
        chk(nd_out == exp_nd, "R6 nd_out", nd_out, exp_nd);
        chk(iss_valid == (win >= 0), "R4 iss_valid", iss_valid, win >= 0);
        if (win >= 0) begin
            chk(iss_tid == TID_W'(win), "R4 iss_tid", iss_tid, win);
            chk(iss_opc == m_opc[win] && iss_dst == m_dst[win] && iss_src == m_src[win],
                "R5 issue fields", {iss_opc, iss_dst, iss_src}, {m_opc[win], m_dst[win], m_src[win]});
        end
        for (int t = 0; t < T; t++) begin
            n_take[t] = fill_valid && fill_tid == TID_W'(t) && (!m_v[t] || leave[t]);
            n_v[t] = n_take[t] ? 1'b1 : (leave[t] ? 1'b0 : m_v[t]);
            n_hold[t] = leave[t] ? 1'b1 : (!line[t] ? 1'b0 : m_hold[t]);
        end
    endtask

    task automatic commit();
        @(posedge clk);
        for (int t = 0; t < T; t++) begin
            if (n_take[t]) begin
                m_nop[t] = fill_nop; m_opc[t] = fill_opc; m_dst[t] = fill_dst;
                m_used[t] = fill_used; m_src[t] = fill_src;
            end
            m_v[t] = n_v[t];
            m_hold[t] = n_hold[t];
        end
        @(negedge clk);
    endtask

    task automatic cyc(input bit fv, input int tid, input bit nop, input int opc,
                       input int dst, input logic [S-1:0] used, input logic [SRCV_W-1:0] src,
                       input logic [T*S-1:0] rdy, input logic [T-1:0] oth);
        if (pending) commit();
        pending = 1;
        fill_valid = fv; fill_tid = TID_W'(tid); fill_nop = nop;
        fill_opc = OPC_W'(opc); fill_dst = REG_W'(dst); fill_used = used;
        fill_src = src; src_rdy = rdy; other_nd = oth;
        #1;
        model_compare();
    endtask

    task automatic idle(input logic [T*S-1:0] rdy, input logic [T-1:0] oth);
        cyc(0, 0, 0, 0, 0, '0, '0, rdy, oth);
    endtask

    localparam logic [T*S-1:0] ALL = '1;

    initial begin
        rst = 1; fill_valid = 0; fill_tid = '0; fill_nop = 0; fill_opc = '0;
        fill_dst = '0; fill_used = '0; fill_src = '0; src_rdy = '0; other_nd = '0;
        for (int t = 0; t < T; t++) begin
            m_v[t] = 0; m_nop[t] = 0; m_hold[t] = 0; m_opc[t] = '0;
            m_dst[t] = '0; m_used[t] = '0; m_src[t] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        idle('0, '0);
        chk(slot_full == 0 && nd_out == 0 && iss_valid == 0, "R1 reset outputs",
            {slot_full, nd_out, iss_valid}, 0);

        // R2 / R3 / R6: fill, ignored second fill, partial readiness
        cyc(1, 1, 0, 'h11, 3, 2'b11, {6'd6, 6'd5}, '0, '0);
        cyc(1, 1, 0, 'h22, 4, 2'b11, {6'd8, 6'd7}, '0, '0);
        chk(slot_full[1] == 1, "R2 slot stored", slot_full[1], 1);
        chk(nd_out[1] == 1, "R6 not-done raised", nd_out[1], 1);
        idle(8'b0000_0100, '0);
        chk(iss_valid == 0, "R3 one source not ready", iss_valid, 0);
        idle(8'b0000_1100, '0);
        chk(iss_valid == 1 && iss_opc == 'h11, "R2 full-slot fill ignored", iss_opc, 'h11);
        idle(ALL, '0);
        chk(slot_full[1] == 0, "R5 slot cleared after issue", slot_full[1], 0);

        // R3: unused source ready bit ignored
        cyc(1, 2, 0, 'h33, 9, 2'b01, {6'd2, 6'd1}, 8'b0001_0000, '0);
        idle(8'b0001_0000, '0);
        chk(iss_valid == 1 && iss_tid == 2, "R3 unused source ignored", iss_tid, 2);

        // R4: fixed priority order
        for (int t = T - 1; t >= 0; t--) cyc(1, t, 0, 'h40 + t, t, 2'b11, '0, '0, '0);
        for (int t = 0; t < T; t++) begin
            idle(ALL, '0);
            chk(iss_valid == 1 && iss_tid == TID_W'(t), "R4 lowest index first", iss_tid, t);
        end

        // R10: blocked high-priority thread does not block a lower one
        cyc(1, 0, 0, 'h50, 1, 2'b11, '0, '0, '0);
        cyc(1, 2, 0, 'h52, 2, 2'b11, '0, '0, '0);
        idle(8'b0011_0000, '0);
        chk(iss_valid == 1 && iss_tid == 2, "R10 lower thread proceeds", iss_tid, 2);
        idle(ALL, '0);
        chk(iss_valid == 1 && iss_tid == 0, "R10 blocked thread later", iss_tid, 0);

        // R7 / R9: hold back while the shared line is high
        cyc(1, 1, 0, 'h61, 5, 2'b11, '0, ALL, 4'b0010);
        idle(ALL, 4'b0010);
        chk(iss_valid == 1 && iss_tid == 1, "R7 current instruction issues", iss_tid, 1);
        cyc(1, 1, 0, 'h62, 6, 2'b11, '0, ALL, 4'b0010);
        idle(ALL, 4'b0010);
        chk(slot_full[1] == 1, "R9 fill accepted while held", slot_full[1], 1);
        chk(iss_valid == 0, "R7 held while line high", iss_valid, 0);
        chk(nd_out[1] == 0, "R6 no not-done while ahead", nd_out[1], 0);
        idle(ALL, 4'b0010);
        chk(iss_valid == 0, "R7 still held", iss_valid, 0);
        idle(ALL, 4'b0000);
        chk(iss_valid == 1 && iss_opc == 'h62, "R7 resumes when line low", iss_opc, 'h62);

        // R8: null operation
        cyc(1, 3, 1, 'h70, 0, 2'b00, '0, ALL, 4'b1000);
        idle(ALL, 4'b1000);
        chk(slot_full[3] == 1 && nd_out[3] == 0 && iss_valid == 0, "R8 null never issues",
            {slot_full[3], nd_out[3], iss_valid}, 3'b100);
        cyc(1, 3, 0, 'h71, 7, 2'b11, '0, ALL, 4'b1000);
        chk(slot_full[3] == 0, "R8 null retired", slot_full[3], 0);
        idle(ALL, 4'b1000);
        chk(slot_full[3] == 1 && iss_valid == 0, "R8 null counts for ordering", iss_valid, 0);
        idle(ALL, 4'b0000);
        chk(iss_valid == 1 && iss_opc == 'h71, "R8 next op after line low", iss_opc, 'h71);

        // random traffic, compared against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            logic [T-1:0] oth;
            oth = T'($urandom & $urandom);
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, T - 1), $urandom_range(0, 7) == 0,
                $urandom, $urandom, S'($urandom), SRCV_W'($urandom), (T*S)'($urandom | $urandom), oth);
        end
        commit();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule